// File: doc/BRIEF.md
# Accelerator Control Register File

This block is the software-facing control plane of a compute accelerator. It is an AXI4-Lite slave holding a small set of 32-bit registers. A control word starts the core and reports its progress. Three registers gate one interrupt line. A set of argument registers passes operands to the core and collects its result. Single-beat accesses only: each request carries one address and one data word, with no bursts.

On the core side the block drives a start level, a one-cycle continue pulse and the operand values, with a one-cycle valid pulse for the second operand. It samples the core's done, idle and ready levels and its result word with a valid strobe. Each control bit has its own access rule. Start stays set until the core accepts it. Done and ready stay set until the control word is read. Status bits flip when software writes a 1 to them. The operand valid flag drops by itself. Auto-restart sets start again after every completion.

Software writes the operands, writes 1 to start and then waits. It either polls the control word or takes the interrupt. It then reads the result and its valid flag.

Top module: `accel_ctrl_regs`

## Requirements
- R1: After reset every stored bit is 0. `core_start` and `irq` are low. A read of 0x00 returns only the live idle level in bit 2.
- R2: Writing 1 to bit 0 of 0x00, with byte strobe 0 set, raises `core_start` after the write. Writing 0 there has no effect. With auto-restart clear, `core_start` falls on the cycle after `core_ready` is seen.
- R3: Bit 1 of 0x00 is set by `core_done` and bit 3 is set by `core_ready`. A read of 0x00 clears both bits. Bit 2 is the live `core_idle` level. A read of 0x00 that returns done = 1 produces exactly one cycle of `core_continue`.
- R4: Bit 7 of 0x00 is auto-restart and is read/write. While it is set, `core_ready` leaves `core_start` at 1 on the next cycle, whether or not start was set before.
- R5: At 0x0C, bit 0 is set by a done event and bit 1 by a ready event. Writing 1 to a bit inverts it. Writing 0 leaves it unchanged.
- R6: `irq` is high exactly when bit 0 of 0x04 is set and some bit of 0x0C is set whose enable at 0x08 is also set. At 0x08, bit 0 enables done and bit 1 enables ready.
- R7: Operand A at 0x10 is 8 bits wide and read/write. It drives `op_a`. Bits above bit 7 are not stored and read as 0.
- R8: Operand B at 0x18 is 8 bits wide and read/write, and drives `op_b`. Writing 1 to bit 0 of 0x1C raises `op_b_vld` for exactly one cycle, and 0x1C then reads 0. Writing 0 to 0x1C gives no pulse.
- R9: While `res_vld` is high, `res_data` is captured into 0x28 (read-only), and bit 0 of 0x2C is set. A read of 0x2C clears that bit. Writes to 0x28 are ignored.
- R10: A write changes only the byte lanes whose strobe is set. A write with no strobe in the lane that holds a field leaves that field unchanged.
- R11: Reads of reserved or unmapped offsets (0x14, 0x20, 0x24, 0x30 to 0x3C) and of reserved bits return 0 with an OKAY response. Writes to them change nothing.
- R12: Write address and write data are accepted in either order. Exactly one OKAY write response follows, and only after both have been accepted. A response stays valid until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| core_start | output | 1 | Start level to the core |
| core_continue | output | 1 | One-cycle pulse after done is read |
| core_done | input | 1 | Core finished |
| core_idle | input | 1 | Core idle level |
| core_ready | input | 1 | Core accepted start / can take new inputs |
| op_a | output | ARG_W | Operand A |
| op_b | output | ARG_W | Operand B |
| op_b_vld | output | 1 | One-cycle valid pulse for operand B |
| res_data | input | ARG_W | Result from the core |
| res_vld | input | 1 | Result valid strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 6-bit address and 8-bit arguments. The 6-bit address spans all sixteen word slots. Every reserved and unmapped offset, including the top slots 0x30 to 0x3C, can therefore be read and written. With 8-bit arguments, a write of a wider value shows that bits above the field are dropped. It also shows that a strobe on byte 1 alone leaves the operand unchanged. A stub driven from bench tasks issues done, ready and result events at chosen cycles. This exercises start clearing, auto-restart re-arming and the set and toggle ordering of the status register.

// File: rtl/acr_pkg.sv
package acr_pkg;

    localparam int DW = 32;
    localparam int SW = DW / 8;

    // register offsets (bytes)
    localparam logic [15:0] OFF_CTRL = 16'h00;
    localparam logic [15:0] OFF_GIE  = 16'h04;
    localparam logic [15:0] OFF_IER  = 16'h08;
    localparam logic [15:0] OFF_ISR  = 16'h0C;
    localparam logic [15:0] OFF_OPA  = 16'h10;
    localparam logic [15:0] OFF_OPB  = 16'h18;
    localparam logic [15:0] OFF_OPBV = 16'h1C;
    localparam logic [15:0] OFF_RES  = 16'h28;
    localparam logic [15:0] OFF_RESV = 16'h2C;

    // control word bit positions
    localparam int CB_START = 0;
    localparam int CB_DONE  = 1;
    localparam int CB_IDLE  = 2;
    localparam int CB_READY = 3;
    localparam int CB_AUTO  = 7;

    // interrupt event positions
    localparam int EV_DONE  = 0;
    localparam int EV_READY = 1;
    localparam int EV_N     = 2;

    typedef logic [DW-1:0] word_t;
    typedef logic [SW-1:0] strb_t;

    typedef struct packed {
        word_t data;
        strb_t strb;
    } wbeat_t;

    // keep old bytes where the strobe is low
    function automatic word_t merge_bytes(word_t old, wbeat_t b);
        word_t r;
        for (int i = 0; i < SW; i++)
            r[i*8 +: 8] = b.strb[i] ? b.data[i*8 +: 8] : old[i*8 +: 8];
        return r;
    endfunction

    function automatic logic hits(logic [15:0] addr, logic [15:0] off);
        return addr[15:2] == off[15:2];
    endfunction

endpackage

// File: rtl/acr_axil_port.sv
module acr_axil_port
    import acr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  word_t             s_wdata,
    input  strb_t             s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    output logic              s_rvalid,
    input  logic              s_rready,
    output word_t             s_rdata,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output wbeat_t            wr_beat,
    output logic              rd_fire,
    output logic [ADDR_W-1:0] rd_addr,
    input  word_t             rd_word
);

    logic aw_pend, w_pend, bvalid_q, rvalid_q;
    logic [ADDR_W-1:0] aw_q;
    wbeat_t            w_q;
    word_t             rdata_q;

    assign s_awready = !aw_pend;
    assign s_wready  = !w_pend;
    assign s_bvalid  = bvalid_q;
    assign s_arready = !rvalid_q;
    assign s_rvalid  = rvalid_q;
    assign s_rdata   = rdata_q;

    assign wr_fire = aw_pend && w_pend && !bvalid_q;
    assign wr_addr = aw_q;
    assign wr_beat = w_q;
    assign rd_fire = s_arvalid && !rvalid_q;
    assign rd_addr = s_araddr;

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_pend  <= 1'b0;
            w_pend   <= 1'b0;
            bvalid_q <= 1'b0;
            aw_q     <= '0;
            w_q      <= '0;
        end else begin
            if (s_awvalid && !aw_pend) begin
                aw_pend <= 1'b1;
                aw_q    <= s_awaddr;
            end
            if (s_wvalid && !w_pend) begin
                w_pend <= 1'b1;
                w_q    <= '{data: s_wdata, strb: s_wstrb};
            end
            if (wr_fire) begin
                aw_pend  <= 1'b0;
                w_pend   <= 1'b0;
                bvalid_q <= 1'b1;
            end else if (s_bready) begin
                bvalid_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (rd_fire) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_word;
        end else if (s_rready) begin
            rvalid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/acr_ctrl_irq.sv
module acr_ctrl_irq
    import acr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  wbeat_t            wr_beat,
    input  logic              rd_fire,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              core_done,
    input  logic              core_idle,
    input  logic              core_ready,
    output logic              core_start,
    output logic              core_continue,
    output logic              irq,
    output word_t             rd_word,
    output logic              st_auto,
    output logic              st_gie,
    output logic              st_done
);

    logic start_q, done_q, ready_q, auto_q, gie_q, cont_q;
    logic [EV_N-1:0] ier_q, isr_q, ev;
    logic  wr_ctrl, wr_gie, wr_ier, wr_isr, rd_ctrl;
    word_t wv;

    assign wr_ctrl = wr_fire && hits(16'(wr_addr), OFF_CTRL);
    assign wr_gie  = wr_fire && hits(16'(wr_addr), OFF_GIE);
    assign wr_ier  = wr_fire && hits(16'(wr_addr), OFF_IER);
    assign wr_isr  = wr_fire && hits(16'(wr_addr), OFF_ISR);
    assign rd_ctrl = rd_fire && hits(16'(rd_addr), OFF_CTRL);
    assign wv      = merge_bytes('0, wr_beat);   // data with unstrobed lanes zeroed

    assign ev[EV_DONE]  = core_done;
    assign ev[EV_READY] = core_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            auto_q  <= 1'b0;
            done_q  <= 1'b0;
            ready_q <= 1'b0;
            cont_q  <= 1'b0;
            gie_q   <= 1'b0;
            ier_q   <= '0;
        end else begin
            if (wr_ctrl && wv[CB_START])
                start_q <= 1'b1;
            else if (core_ready)
                start_q <= auto_q;
            if (wr_ctrl && wr_beat.strb[0])
                auto_q <= wv[CB_AUTO];
            if (core_done)    done_q <= 1'b1;
            else if (rd_ctrl) done_q <= 1'b0;
            if (core_ready)   ready_q <= 1'b1;
            else if (rd_ctrl) ready_q <= 1'b0;
            cont_q <= rd_ctrl && done_q;
            if (wr_gie && wr_beat.strb[0]) gie_q <= wv[0];
            if (wr_ier && wr_beat.strb[0]) ier_q <= wv[EV_N-1:0];
        end
    end

    // one status flop per event: event set beats a toggle write
    for (genvar e = 0; e < EV_N; e++) begin : g_isr
        always_ff @(posedge clk) begin
            if (rst)
                isr_q[e] <= 1'b0;
            else if (ev[e])
                isr_q[e] <= 1'b1;
            else if (wr_isr && wv[e])
                isr_q[e] <= ~isr_q[e];
        end
    end

    assign irq           = gie_q && |(isr_q & ier_q);
    assign core_start    = start_q;
    assign core_continue = cont_q;
    assign st_auto       = auto_q;
    assign st_gie        = gie_q;
    assign st_done       = done_q;

    always_comb begin
        rd_word = '0;
        if (hits(16'(rd_addr), OFF_CTRL)) begin
            rd_word[CB_START] = start_q;
            rd_word[CB_DONE]  = done_q;
            rd_word[CB_IDLE]  = core_idle;
            rd_word[CB_READY] = ready_q;
            rd_word[CB_AUTO]  = auto_q;
        end else if (hits(16'(rd_addr), OFF_GIE)) begin
            rd_word[0] = gie_q;
        end else if (hits(16'(rd_addr), OFF_IER)) begin
            rd_word[EV_N-1:0] = ier_q;
        end else if (hits(16'(rd_addr), OFF_ISR)) begin
            rd_word[EV_N-1:0] = isr_q;
        end
    end

endmodule

// File: rtl/acr_arg_bank.sv
module acr_arg_bank
    import acr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int ARG_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  wbeat_t            wr_beat,
    input  logic              rd_fire,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ARG_W-1:0]  res_data,
    input  logic              res_vld,
    output logic [ARG_W-1:0]  op_a,
    output logic [ARG_W-1:0]  op_b,
    output logic              op_b_vld,
    output word_t             rd_word
);

    logic [ARG_W-1:0] a_q, b_q, res_q;
    logic  bv_q, resv_q;
    word_t a_m, b_m;
    logic  wr_a, wr_b, wr_bv, rd_resv;

    assign wr_a    = wr_fire && hits(16'(wr_addr), OFF_OPA);
    assign wr_b    = wr_fire && hits(16'(wr_addr), OFF_OPB);
    assign wr_bv   = wr_fire && hits(16'(wr_addr), OFF_OPBV);
    assign rd_resv = rd_fire && hits(16'(rd_addr), OFF_RESV);
    assign a_m     = merge_bytes(DW'(a_q), wr_beat);
    assign b_m     = merge_bytes(DW'(b_q), wr_beat);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            bv_q   <= 1'b0;
            res_q  <= '0;
            resv_q <= 1'b0;
        end else begin
            if (wr_a) a_q <= a_m[ARG_W-1:0];
            if (wr_b) b_q <= b_m[ARG_W-1:0];
            bv_q <= wr_bv && wr_beat.strb[0] && wr_beat.data[0];
            if (res_vld) begin
                res_q  <= res_data;
                resv_q <= 1'b1;
            end else if (rd_resv) begin
                resv_q <= 1'b0;
            end
        end
    end

    assign op_a     = a_q;
    assign op_b     = b_q;
    assign op_b_vld = bv_q;

    always_comb begin
        rd_word = '0;
        if      (hits(16'(rd_addr), OFF_OPA))  rd_word[ARG_W-1:0] = a_q;
        else if (hits(16'(rd_addr), OFF_OPB))  rd_word[ARG_W-1:0] = b_q;
        else if (hits(16'(rd_addr), OFF_OPBV)) rd_word[0]         = bv_q;
        else if (hits(16'(rd_addr), OFF_RES))  rd_word[ARG_W-1:0] = res_q;
        else if (hits(16'(rd_addr), OFF_RESV)) rd_word[0]         = resv_q;
    end

endmodule

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs
    import acr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int ARG_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              core_start,
    output logic              core_continue,
    input  logic              core_done,
    input  logic              core_idle,
    input  logic              core_ready,
    output logic [ARG_W-1:0]  op_a,
    output logic [ARG_W-1:0]  op_b,
    output logic              op_b_vld,
    input  logic [ARG_W-1:0]  res_data,
    input  logic              res_vld,
    output logic              irq
);

    logic              wr_fire, rd_fire;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    wbeat_t            wr_beat;
    word_t             rd_word, rd_ctrl_w, rd_arg_w;
    logic              st_auto, st_gie, st_done;

    assign s_bresp = 2'b00;
    assign s_rresp = 2'b00;
    assign rd_word = rd_ctrl_w | rd_arg_w;

    acr_axil_port #(.ADDR_W(ADDR_W)) u_port (
        .clk(clk), .rst(rst),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
        .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_beat(wr_beat),
        .rd_fire(rd_fire), .rd_addr(rd_addr), .rd_word(rd_word)
    );

    acr_ctrl_irq #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_beat(wr_beat),
        .rd_fire(rd_fire), .rd_addr(rd_addr),
        .core_done(core_done), .core_idle(core_idle), .core_ready(core_ready),
        .core_start(core_start), .core_continue(core_continue), .irq(irq),
        .rd_word(rd_ctrl_w),
        .st_auto(st_auto), .st_gie(st_gie), .st_done(st_done)
    );

    acr_arg_bank #(.ADDR_W(ADDR_W), .ARG_W(ARG_W)) u_args (
        .clk(clk), .rst(rst),
        .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_beat(wr_beat),
        .rd_fire(rd_fire), .rd_addr(rd_addr),
        .res_data(res_data), .res_vld(res_vld),
        .op_a(op_a), .op_b(op_b), .op_b_vld(op_b_vld),
        .rd_word(rd_arg_w)
    );

endmodule

// File: rtl/acr_chk.sv
module acr_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_fire,
    input logic        core_start,
    input logic        core_ready,
    input logic        core_done,
    input logic        op_b_vld,
    input logic        irq,
    input logic        st_auto,
    input logic        st_gie,
    input logic        st_done,
    input logic        s_rvalid,
    input logic        s_rready,
    input logic [31:0] s_rdata,
    input logic        s_bvalid,
    input logic        s_bready,
    input logic [1:0]  s_bresp,
    input logic [1:0]  s_rresp
);

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (core_start && core_ready && !st_auto && !wr_fire) |=> !core_start);

    // R4
    auto_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (core_ready && st_auto) |=> core_start);

    // R3
    done_latch_chk: assert property (@(posedge clk) disable iff (rst)
        core_done |=> st_done);

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !st_gie |-> !irq);

    // R8
    opb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        op_b_vld |=> !op_b_vld);

    // R12
    rhold_chk: assert property (@(posedge clk) disable iff (rst)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

    // R12
    bhold_chk: assert property (@(posedge clk) disable iff (rst)
        (s_bvalid && !s_bready) |=> s_bvalid);

    // R12
    wresp_chk: assert property (@(posedge clk) disable iff (rst)
        wr_fire |=> s_bvalid);

    // R11
    okay_chk: assert property (@(posedge clk) disable iff (rst)
        (s_rvalid || s_bvalid) |-> (s_rresp == 2'b00 && s_bresp == 2'b00));

endmodule

bind accel_ctrl_regs acr_chk u_acr_chk (
    .clk(clk), .rst(rst), .wr_fire(wr_fire),
    .core_start(core_start), .core_ready(core_ready), .core_done(core_done),
    .op_b_vld(op_b_vld), .irq(irq),
    .st_auto(st_auto), .st_gie(st_gie), .st_done(st_done),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
    .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_bresp(s_bresp), .s_rresp(s_rresp)
);

// File: tb/accel_ctrl_regs_bench.sv
`timescale 1ns/1ps
module accel_ctrl_regs_bench;
    import acr_pkg::*;

    localparam int AW = 6;
    localparam int AG = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    logic          awvalid = 0, wvalid = 0, arvalid = 0;
    logic          bready = 1, rready = 1;
    logic [AW-1:0] awaddr = '0, araddr = '0;
    logic [31:0]   wdata = '0;
    logic [3:0]    wstrb = '0;
    logic          awready, wready, bvalid, arready, rvalid;
    logic [1:0]    bresp, rresp;
    logic [31:0]   rdata;
    logic          core_start, core_continue, op_b_vld, irq;
    logic          core_done = 0, core_idle = 1, core_ready = 0, res_vld = 0;
    logic [AG-1:0] op_a, op_b, res_data = '0;

    accel_ctrl_regs #(.ADDR_W(AW), .ARG_W(AG)) u_accel_ctrl_regs (
        .clk(clk), .rst(rst),
        .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
        .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
        .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
        .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
        .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
        .core_start(core_start), .core_continue(core_continue),
        .core_done(core_done), .core_idle(core_idle), .core_ready(core_ready),
        .op_a(op_a), .op_b(op_b), .op_b_vld(op_b_vld),
        .res_data(res_data), .res_vld(res_vld), .irq(irq)
    );

    int checks = 0, errors = 0;
    int vld_cnt = 0, cont_cnt = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: compares each read response against the queued expectation
    always @(negedge clk) begin
        if (op_b_vld)      vld_cnt++;
        if (core_continue) cont_cnt++;
        if (!rst && rvalid) begin
            if (exp_q.size() == 0) begin
                check(0, "R12 unexpected read response", rdata, 0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rdata == e, t, rdata, e);
                check(rresp == 2'b00, "R11 read response OKAY", rresp, 0);
            end
        end
    end

    task automatic axi_rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        araddr = a; arvalid = 1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        arvalid = 0;
        @(negedge clk);
    endtask

    // order 0: together, 1: address first, 2: data first
    task automatic axi_wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s, input int order);
        @(negedge clk);
        if (order != 2) begin awaddr = a; awvalid = 1; end
        if (order != 1) begin wdata = d; wstrb = s; wvalid = 1; end
        @(negedge clk);
        if (order == 1) begin awvalid = 0; wdata = d; wstrb = s; wvalid = 1; end
        else if (order == 2) begin wvalid = 0; awaddr = a; awvalid = 1; end
        else begin awvalid = 0; wvalid = 0; end
        if (order != 0) begin
            check(!bvalid, "R12 no response before both channels", bvalid, 0);
            @(negedge clk);
            awvalid = 0; wvalid = 0;
        end
        while (!bvalid) @(negedge clk);
        check(bresp == 2'b00, "R12 write response OKAY", bresp, 0);
        @(negedge clk);
    endtask

    task automatic core_evt(input bit d, input bit r);
        @(negedge clk);
        core_done = d; core_ready = r;
        @(negedge clk);
        core_done = 0; core_ready = 0;
    endtask

    task automatic res_evt(input logic [AG-1:0] v);
        @(negedge clk);
        res_data = v; res_vld = 1;
        @(negedge clk);
        res_vld = 0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 0;

        // R1 reset state
        check(core_start == 0, "R1 start after reset", core_start, 0);
        check(irq == 0, "R1 irq after reset", irq, 0);
        check(op_a == 0, "R1 op_a after reset", op_a, 0);
        axi_rd(6'h00, 32'h4, "R1 control word idle only");
        axi_rd(6'h04, 0, "R1 global enable");
        axi_rd(6'h08, 0, "R1 event enables");
        axi_rd(6'h0C, 0, "R1 status");
        axi_rd(6'h2C, 0, "R1 result valid");

        // R2 start handshake
        core_idle = 0;
        axi_wr(6'h00, 32'h1, 4'hF, 0);
        check(core_start == 1, "R2 start set by write", core_start, 1);
        axi_wr(6'h00, 32'h0, 4'hF, 0);
        check(core_start == 1, "R2 writing 0 has no effect", core_start, 1);
        core_evt(0, 1);
        check(core_start == 0, "R2 start cleared on ready", core_start, 0);

        // R3 done/ready latch and clear on read, continue pulse
        core_evt(1, 0);
        axi_rd(6'h00, 32'h0A, "R3 done and ready latched");
        check(cont_cnt == 1, "R3 continue pulse once", cont_cnt, 1);
        axi_rd(6'h00, 32'h00, "R3 cleared by read");
        check(cont_cnt == 1, "R3 no continue without done", cont_cnt, 1);
        core_idle = 1;
        axi_rd(6'h00, 32'h04, "R3 idle live");

        // R5 status toggle on write
        axi_rd(6'h0C, 32'h3, "R5 both events recorded");
        axi_wr(6'h0C, 32'h1, 4'hF, 0);
        axi_rd(6'h0C, 32'h2, "R5 toggle bit 0 off");
        axi_wr(6'h0C, 32'h3, 4'hF, 0);
        axi_rd(6'h0C, 32'h1, "R5 toggle both bits");
        axi_wr(6'h0C, 32'h1, 4'hF, 0);
        axi_rd(6'h0C, 32'h0, "R5 status clear");

        // R6 interrupt gating
        axi_wr(6'h08, 32'h1, 4'hF, 0);
        axi_wr(6'h04, 32'h1, 4'hF, 0);
        check(irq == 0, "R6 no pending event", irq, 0);
        core_evt(1, 0);
        check(irq == 1, "R6 done event raises irq", irq, 1);
        axi_wr(6'h04, 32'h0, 4'hF, 0);
        check(irq == 0, "R6 global enable off", irq, 0);
        axi_wr(6'h04, 32'h1, 4'hF, 0);
        check(irq == 1, "R6 global enable on", irq, 1);
        axi_wr(6'h08, 32'h2, 4'hF, 0);
        check(irq == 0, "R6 done masked", irq, 0);
        core_evt(0, 1);
        check(irq == 1, "R6 ready event enabled", irq, 1);
        axi_wr(6'h0C, 32'h2, 4'hF, 0);
        check(irq == 0, "R6 ready acknowledged", irq, 0);
        axi_wr(6'h0C, 32'h1, 4'hF, 0);
        axi_wr(6'h08, 32'h0, 4'hF, 0);
        axi_wr(6'h04, 32'h0, 4'hF, 0);
        axi_rd(6'h00, 32'h0E, "R3 done ready idle");
        check(cont_cnt == 2, "R3 second continue pulse", cont_cnt, 2);

        // R4 auto-restart
        axi_wr(6'h00, 32'h80, 4'hF, 0);
        check(core_start == 0, "R4 auto bit alone no start", core_start, 0);
        axi_rd(6'h00, 32'h84, "R4 auto bit readback");
        axi_wr(6'h00, 32'h81, 4'hF, 0);
        check(core_start == 1, "R4 start with auto", core_start, 1);
        core_evt(0, 1);
        check(core_start == 1, "R4 start re-armed after ready", core_start, 1);
        axi_wr(6'h00, 32'h00, 4'hF, 0);
        check(core_start == 1, "R4 auto off keeps start", core_start, 1);
        core_evt(0, 1);
        check(core_start == 0, "R4 start drops without auto", core_start, 0);
        axi_rd(6'h00, 32'h0C, "R4 ready idle after run");
        axi_wr(6'h0C, 32'h2, 4'hF, 0);

        // R7 operand A
        axi_wr(6'h10, 32'h1A5, 4'hF, 0);
        check(op_a == 8'hA5, "R7 op_a drive", op_a, 8'hA5);
        axi_rd(6'h10, 32'hA5, "R7 op_a readback drops high bits");

        // R10 byte strobes
        axi_wr(6'h10, 32'h5A, 4'h0, 0);
        axi_rd(6'h10, 32'hA5, "R10 no strobe keeps op_a");
        axi_wr(6'h10, 32'h3300, 4'h2, 0);
        check(op_a == 8'hA5, "R10 byte1 strobe leaves op_a", op_a, 8'hA5);
        axi_wr(6'h00, 32'h1, 4'hE, 0);
        check(core_start == 0, "R10 start needs byte0 strobe", core_start, 0);

        // R8 operand B and its valid pulse
        axi_wr(6'h18, 32'h3C, 4'hF, 0);
        check(op_b == 8'h3C, "R8 op_b drive", op_b, 8'h3C);
        axi_rd(6'h18, 32'h3C, "R8 op_b readback");
        axi_wr(6'h1C, 32'h1, 4'hF, 0);
        check(vld_cnt == 1, "R8 valid pulse one cycle", vld_cnt, 1);
        axi_rd(6'h1C, 32'h0, "R8 valid self-cleared");
        axi_wr(6'h1C, 32'h0, 4'hF, 0);
        check(vld_cnt == 1, "R8 writing 0 no pulse", vld_cnt, 1);

        // R9 result capture
        res_evt(8'h5A);
        axi_rd(6'h28, 32'h5A, "R9 result captured");
        axi_rd(6'h2C, 32'h1, "R9 result valid set");
        axi_rd(6'h2C, 32'h0, "R9 result valid cleared on read");
        axi_wr(6'h28, 32'h77, 4'hF, 0);
        axi_rd(6'h28, 32'h5A, "R9 result read-only");

        // R11 reserved space
        axi_wr(6'h14, 32'hFFFF_FFFF, 4'hF, 0);
        axi_rd(6'h14, 0, "R11 reserved 0x14");
        axi_rd(6'h20, 0, "R11 unmapped 0x20");
        axi_rd(6'h24, 0, "R11 reserved 0x24");
        axi_wr(6'h3C, 32'hFFFF_FFFF, 4'hF, 0);
        axi_rd(6'h30, 0, "R11 unmapped 0x30");
        axi_rd(6'h3C, 0, "R11 unmapped 0x3C");
        axi_wr(6'h04, 32'hFFFF_FFFF, 4'hF, 0);
        axi_rd(6'h04, 32'h1, "R11 reserved bits of global enable");
        axi_wr(6'h04, 32'h0, 4'hF, 0);
        check(irq == 0, "R11 no side effect on irq", irq, 0);

        // R12 channel ordering
        axi_wr(6'h10, 32'h11, 4'hF, 1);
        axi_rd(6'h10, 32'h11, "R12 address before data");
        axi_wr(6'h10, 32'h22, 4'hF, 2);
        axi_rd(6'h10, 32'h22, "R12 data before address");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R12 every read answered", exp_q.size(), 0);
        summary();
    end

endmodule